// File: doc/BRIEF.md
# Data Access Break Comparator

This debug-support block watches a stream of data access cycles and raises a break request when one of them matches a programmed target. The target is a break address, plus an optional data value with a per-bit mask. Configuration inputs also choose the access size to accept, the transfer direction, and which of two observed streams is compared. The first stream carries logical accesses made by executed CPU instructions. The second carries physical accesses from every master on the shared bus.

The address match gets coarser as the access gets wider. A longword access ignores the two lowest address bits, a word access ignores bit 0, and a byte access compares every bit. So one programmed address catches the naturally aligned longword, word and byte that contain it. When data comparison is on, the observed data word is checked in a lane that depends on the access. A longword uses all 32 bits. A word or byte uses the low half, with a byte carried in both bytes of that half. A word access flagged as an upper-half move uses the high half.

The result is a registered pulse, one clock wide, in the cycle after a matching access.

Top module: `dab_break_unit`

## Requirements
- R1: For a longword access (cycle size code 2), only address bits 31..2 are compared with `cfg_addr`.
- R2: For a word access (cycle size code 1), only address bits 31..1 are compared.
- R3: For a byte access (cycle size code 0), all 32 address bits are compared. Cycle size code 3 never matches.
- R4: `cfg_size` is a size filter: 0 accepts any size, 1 byte only, 2 word only, 3 longword only. With data comparison enabled, filter 0 never produces a break.
- R5: With `cfg_data_en` set, a break needs both the address condition and the data condition. A mask bit at 1 removes that data bit from the comparison.
- R6: The data comparison covers bits 31..0 for a longword, and bits 15..0 for a word or byte access. For word and byte accesses, bits 31..16 of data, value and mask have no effect.
- R7: A word access with its upper-half flag set compares data bits 31..16 only, and bits 15..0 have no effect.
- R8: `cfg_bus_sel` 0 compares the CPU stream and 1 compares the shared-bus stream. The other stream has no effect.
- R9: `cfg_dir` 1 accepts reads only (write flag 0), 2 accepts writes only, and 0 or 3 accepts both.
- R10: No break is produced while `cfg_enable` is low or the selected stream's valid strobe is low.
- R11: `brk_o` rises in the clock after the matching access, lasts one clock per matching access, and is 0 during and right after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Comparator enable |
| cfg_bus_sel | input | 1 | Stream select: 0 CPU, 1 shared bus |
| cfg_addr | input | 32 | Break address |
| cfg_data | input | 32 | Break data value |
| cfg_mask | input | 32 | Data mask, 1 = bit ignored |
| cfg_size | input | 2 | Size filter |
| cfg_data_en | input | 1 | Include data in the condition |
| cfg_dir | input | 2 | Direction filter |
| cpu_vld | input | 1 | CPU stream cycle valid |
| cpu_addr | input | 32 | CPU stream logical address |
| cpu_size | input | 2 | CPU stream access size |
| cpu_data | input | 32 | CPU stream data |
| cpu_wr | input | 1 | CPU stream write flag |
| cpu_hi | input | 1 | CPU stream upper-half move flag |
| sys_vld | input | 1 | Shared-bus cycle valid |
| sys_addr | input | 32 | Shared-bus physical address |
| sys_size | input | 2 | Shared-bus access size |
| sys_data | input | 32 | Shared-bus data |
| sys_wr | input | 1 | Shared-bus write flag |
| sys_hi | input | 1 | Shared-bus upper-half move flag |
| brk_o | output | 1 | Registered break pulse |

## Verification
The assertions assume that the configuration inputs and the selected stream are stable and known at each rising edge. They also assume that reset is asserted from the first edge. The bench changes every input only on falling edges and holds reset over the first cycles. In the random phase it draws addresses and data close to the programmed values, so that hits, size codes, including the reserved code, and direction mixes all occur while staying inside those assumptions.

// File: rtl/dab_pkg.sv
package dab_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_LONG = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        FLT_ANY  = 2'd0,
        FLT_BYTE = 2'd1,
        FLT_WORD = 2'd2,
        FLT_LONG = 2'd3
    } size_flt_e;

    typedef enum logic [1:0] {
        DIR_BOTH  = 2'd0,
        DIR_READ  = 2'd1,
        DIR_WRITE = 2'd2,
        DIR_BOTH2 = 2'd3
    } dir_flt_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic [DATA_W-1:0] data;
        logic              write;
        logic              upper;
    } obs_cycle_t;

    function automatic logic size_pass(size_flt_e flt, acc_size_e sz, logic data_en);
        case (flt)
            FLT_ANY:  return !data_en;
            FLT_BYTE: return sz == ACC_BYTE;
            FLT_WORD: return sz == ACC_WORD;
            default:  return sz == ACC_LONG;
        endcase
    endfunction

    function automatic logic dir_pass(dir_flt_e flt, logic write);
        case (flt)
            DIR_READ:  return !write;
            DIR_WRITE: return write;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dab_stream_sel.sv
module dab_stream_sel
    import dab_pkg::*;
(
    input  obs_cycle_t cpu_cyc,
    input  obs_cycle_t sys_cyc,
    input  logic       bus_sel,
    output obs_cycle_t sel_cyc
);
    always_comb begin
        sel_cyc = bus_sel ? sys_cyc : cpu_cyc;
    end
endmodule

// File: rtl/dab_addr_cmp.sv
module dab_addr_cmp
    import dab_pkg::*;
(
    input  logic [ADDR_W-1:0] obs_addr,
    input  acc_size_e         obs_size,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] ign;

    always_comb begin
        ign = '0;
        case (obs_size)
            ACC_LONG: ign[1:0] = 2'b11;
            ACC_WORD: ign[0]   = 1'b1;
            default:  ign      = '0;
        endcase
        hit = (((obs_addr ^ ref_addr) & ~ign) == '0) && (obs_size != ACC_RSVD);
    end
endmodule

// File: rtl/dab_data_cmp.sv
module dab_data_cmp
    import dab_pkg::*;
(
    input  logic [DATA_W-1:0] obs_data,
    input  acc_size_e         obs_size,
    input  logic              obs_upper,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] ref_mask,
    output logic              hit
);
    logic [DATA_W-1:0] diff;
    logic              lo_eq;
    logic              hi_eq;

    always_comb begin
        diff  = (obs_data ^ ref_data) & ~ref_mask;
        lo_eq = diff[HALF_W-1:0] == '0;
        hi_eq = diff[DATA_W-1:HALF_W] == '0;
        case (obs_size)
            ACC_LONG: hit = lo_eq && hi_eq;
            ACC_WORD: hit = obs_upper ? hi_eq : lo_eq;
            default:  hit = lo_eq;
        endcase
    end
endmodule

// File: rtl/dab_break_unit.sv
module dab_break_unit
    import dab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_bus_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_data_en,
    input  logic [1:0]        cfg_dir,
    input  logic              cpu_vld,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              cpu_hi,
    input  logic              sys_vld,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic [1:0]        sys_size,
    input  logic [DATA_W-1:0] sys_data,
    input  logic              sys_wr,
    input  logic              sys_hi,
    output logic              brk_o
);
    obs_cycle_t cpu_cyc;
    obs_cycle_t sys_cyc;
    obs_cycle_t sel;
    logic       addr_hit;
    logic       data_hit;
    logic       gate_ok;
    logic       match;

    always_comb begin
        cpu_cyc = '{valid: cpu_vld, addr: cpu_addr, size: acc_size_e'(cpu_size),
                    data: cpu_data, write: cpu_wr, upper: cpu_hi};
        sys_cyc = '{valid: sys_vld, addr: sys_addr, size: acc_size_e'(sys_size),
                    data: sys_data, write: sys_wr, upper: sys_hi};
    end

    dab_stream_sel u_sel (
        .cpu_cyc (cpu_cyc),
        .sys_cyc (sys_cyc),
        .bus_sel (cfg_bus_sel),
        .sel_cyc (sel)
    );

    dab_addr_cmp u_addr (
        .obs_addr (sel.addr),
        .obs_size (sel.size),
        .ref_addr (cfg_addr),
        .hit      (addr_hit)
    );

    dab_data_cmp u_data (
        .obs_data  (sel.data),
        .obs_size  (sel.size),
        .obs_upper (sel.upper),
        .ref_data  (cfg_data),
        .ref_mask  (cfg_mask),
        .hit       (data_hit)
    );

    always_comb begin
        gate_ok = cfg_enable && sel.valid
               && size_pass(size_flt_e'(cfg_size), sel.size, cfg_data_en)
               && dir_pass(dir_flt_e'(cfg_dir), sel.write);
        match   = gate_ok && addr_hit && (!cfg_data_en || data_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) brk_o <= 1'b0;
        else     brk_o <= match;
    end

    // R11: reset clears the pulse
    a_r11_reset_clears: assert property (@(posedge clk) rst |=> !brk_o);

    // R10: a pulse needs enable and a valid selected cycle one clock earlier
    a_r10_gated: assert property (@(posedge clk) disable iff (rst)
        brk_o |-> ($past(cfg_enable) && $past(sel.valid)));

    // R4: data compare with the any-size filter never breaks
    a_r4_data_needs_size: assert property (@(posedge clk) disable iff (rst)
        brk_o |-> !($past(cfg_data_en) && $past(cfg_size) == 2'd0));

    // R1: longword hit agrees on address bits 31..2
    a_r1_long_addr: assert property (@(posedge clk) disable iff (rst)
        (brk_o && $past(sel.size) == ACC_LONG)
            |-> ($past(sel.addr[ADDR_W-1:2]) == $past(cfg_addr[ADDR_W-1:2])));

    // R3: byte hit agrees on every address bit
    a_r3_byte_addr: assert property (@(posedge clk) disable iff (rst)
        (brk_o && $past(sel.size) == ACC_BYTE) |-> ($past(sel.addr) == $past(cfg_addr)));

    // R9: read-only filter never breaks on a write
    a_r9_read_only: assert property (@(posedge clk) disable iff (rst)
        (brk_o && $past(cfg_dir) == 2'd1) |-> !$past(sel.write));
endmodule

// File: tb/dab_break_unit_test.sv
`timescale 1ns/1ps
module dab_break_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0, cfg_bus_sel = 1'b0, cfg_data_en = 1'b0;
    logic [31:0] cfg_addr = '0, cfg_data = '0, cfg_mask = '0;
    logic [1:0]  cfg_size = '0, cfg_dir = '0;
    logic        cpu_vld = 1'b0, cpu_wr = 1'b0, cpu_hi = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_data = '0;
    logic [1:0]  cpu_size = '0;
    logic        sys_vld = 1'b0, sys_wr = 1'b0, sys_hi = 1'b0;
    logic [31:0] sys_addr = '0, sys_data = '0;
    logic [1:0]  sys_size = '0;
    logic        brk_o;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    bit    exp_q = 0;
    string cur_req = "R11";

    always #2 clk = ~clk;

    dab_break_unit uut (.*);

    // Behavioural reference for the value registered at the coming edge
    function automatic bit model();
        bit          v, w, h;
        int unsigned a, d, sz;
        int unsigned flt, diff;
        v  = cfg_bus_sel ? sys_vld : cpu_vld;
        w  = cfg_bus_sel ? sys_wr : cpu_wr;
        h  = cfg_bus_sel ? sys_hi : cpu_hi;
        a  = cfg_bus_sel ? sys_addr : cpu_addr;
        d  = cfg_bus_sel ? sys_data : cpu_data;
        sz = cfg_bus_sel ? sys_size : cpu_size;
        flt = cfg_size;
        if (!cfg_enable || !v) return 0;
        if (cfg_dir == 1 && w) return 0;
        if (cfg_dir == 2 && !w) return 0;
        if (sz == 3) return 0;
        if (flt == 0) begin
            if (cfg_data_en) return 0;
        end else if (flt != sz + 1) return 0;
        if (sz == 2 && (a / 4) != (cfg_addr / 4)) return 0;
        if (sz == 1 && (a / 2) != (cfg_addr / 2)) return 0;
        if (sz == 0 && a != cfg_addr) return 0;
        if (cfg_data_en) begin
            diff = (d ^ cfg_data) & ~cfg_mask;
            if (sz == 2 && diff != 0) return 0;
            if (sz == 1 && h && (diff / 65536) != 0) return 0;
            if (!(sz == 1 && h) && sz != 2 && (diff % 65536) != 0) return 0;
        end
        return 1;
    endfunction

    always @(posedge clk) exp_q <= rst ? 1'b0 : model();

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (brk_o !== exp_q) begin
                fails++;
                $display("FAIL %s model compare: brk_o=%b expected=%b", cur_req, brk_o, exp_q);
            end
        end
    end

    task automatic lit(input bit exp, input string tag);
        checks++;
        if (brk_o !== exp) begin
            fails++;
            $display("FAIL %s directed: brk_o=%b expected=%b", tag, brk_o, exp);
        end
    endtask

    // Drive one access on a stream, check the pulse after the edge, then idle
    task automatic acc(input bit bus, input bit vld, input logic [31:0] a,
                       input logic [1:0] s, input logic [31:0] d, input bit w,
                       input bit hi, input bit exp, input string tag);
        cur_req = tag;
        if (bus) begin
            sys_vld = vld; sys_addr = a; sys_size = s; sys_data = d; sys_wr = w; sys_hi = hi;
        end else begin
            cpu_vld = vld; cpu_addr = a; cpu_size = s; cpu_data = d; cpu_wr = w; cpu_hi = hi;
        end
        @(negedge clk);
        lit(exp, tag);
        cpu_vld = 0; sys_vld = 0;
        @(negedge clk);
        lit(1'b0, "R11");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        lit(1'b0, "R11");
        rst = 0;
        cfg_enable = 1; cfg_addr = 32'h0000_1003; cfg_size = 0; cfg_dir = 0;
        @(negedge clk);
        acc(0, 1, 32'h1000, 2, 0, 0, 0, 1, "R1");
        acc(0, 1, 32'h1004, 2, 0, 0, 0, 0, "R1");
        acc(0, 1, 32'h1002, 1, 0, 0, 0, 1, "R2");
        acc(0, 1, 32'h1000, 1, 0, 0, 0, 0, "R2");
        acc(0, 1, 32'h1003, 0, 0, 0, 0, 1, "R3");
        acc(0, 1, 32'h1002, 0, 0, 0, 0, 0, "R3");
        acc(0, 1, 32'h1003, 3, 0, 0, 0, 0, "R3");
        cfg_size = 3;
        acc(0, 1, 32'h1002, 1, 0, 0, 0, 0, "R4");
        acc(0, 1, 32'h1000, 2, 0, 0, 0, 1, "R4");
        cfg_size = 0; cfg_data_en = 1;
        acc(0, 1, 32'h1000, 2, 0, 0, 0, 0, "R4");
        cfg_size = 3; cfg_data = 32'hDEAD_BEEF; cfg_mask = 0;
        acc(0, 1, 32'h1000, 2, 32'hDEAD_BEEF, 0, 0, 1, "R5");
        acc(0, 1, 32'h1000, 2, 32'hDEAD_BEEE, 0, 0, 0, "R5");
        acc(0, 1, 32'h1004, 2, 32'hDEAD_BEEF, 0, 0, 0, "R5");
        cfg_mask = 32'h1;
        acc(0, 1, 32'h1000, 2, 32'hDEAD_BEEE, 0, 0, 1, "R5");
        cfg_mask = 0; cfg_size = 2; cfg_data = 32'h1234_BEEF;
        acc(0, 1, 32'h1002, 1, 32'hFFFF_BEEF, 0, 0, 1, "R6");
        acc(0, 1, 32'h1002, 1, 32'h0000_BEEE, 0, 0, 0, "R6");
        cfg_size = 1; cfg_data = 32'h0000_5A5A;
        acc(0, 1, 32'h1003, 0, 32'hAAAA_5A5A, 0, 0, 1, "R6");
        acc(0, 1, 32'h1003, 0, 32'h0000_5A5B, 0, 0, 0, "R6");
        cfg_size = 2; cfg_data = 32'hC0DE_0000;
        acc(0, 1, 32'h1002, 1, 32'hC0DE_1111, 0, 1, 1, "R7");
        acc(0, 1, 32'h1002, 1, 32'hC0DF_0000, 0, 1, 0, "R7");
        cfg_data_en = 0; cfg_size = 0;
        acc(1, 1, 32'h1003, 0, 0, 0, 0, 0, "R8");
        cfg_bus_sel = 1;
        acc(1, 1, 32'h1003, 0, 0, 0, 0, 1, "R8");
        acc(0, 1, 32'h1003, 0, 0, 0, 0, 0, "R8");
        cfg_bus_sel = 0; cfg_dir = 1;
        acc(0, 1, 32'h1003, 0, 0, 1, 0, 0, "R9");
        acc(0, 1, 32'h1003, 0, 0, 0, 0, 1, "R9");
        cfg_dir = 2;
        acc(0, 1, 32'h1003, 0, 0, 0, 0, 0, "R9");
        acc(0, 1, 32'h1003, 0, 0, 1, 0, 1, "R9");
        cfg_dir = 0; cfg_enable = 0;
        acc(0, 1, 32'h1003, 0, 0, 0, 0, 0, "R10");
        cfg_enable = 1;
        acc(0, 0, 32'h1003, 0, 0, 0, 0, 0, "R10");
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            if (i % 50 == 0) begin
                cfg_addr    = 32'h0000_2000 | ($urandom % 8);
                cfg_data    = $urandom;
                cfg_mask    = ($urandom % 4 == 0) ? $urandom : 0;
                cfg_size    = 2'($urandom);
                cfg_data_en = 1'($urandom);
                cfg_dir     = 2'($urandom);
                cfg_bus_sel = 1'($urandom);
                cfg_enable  = ($urandom % 8) != 0;
            end
            cpu_vld  = 1'($urandom); sys_vld = 1'($urandom);
            cpu_addr = cfg_addr ^ ($urandom % 8);
            sys_addr = cfg_addr ^ ($urandom % 8);
            cpu_size = 2'($urandom); sys_size = 2'($urandom);
            cpu_data = ($urandom % 2) ? cfg_data : cfg_data ^ (32'h1 << ($urandom % 32));
            sys_data = ($urandom % 2) ? cfg_data : cfg_data ^ (32'h1 << ($urandom % 32));
            cpu_wr = 1'($urandom); sys_wr = 1'($urandom);
            cpu_hi = 1'($urandom); sys_hi = 1'($urandom);
            @(negedge clk);
        end
        cur_req = "R11";
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        lit(1'b0, "R11");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule